// File: doc/BRIEF.md
# Per-Pin Interrupt and Wake Detector

This block holds the interrupt and wake logic for a single GPIO line. It samples the already-filtered input level, qualifies it against a trigger mode (edge or level) and a 2-bit polarity field, and latches two sticky flags: an interrupt status and a wake status. A pending output, gated by an unmask bit, tells the surrounding controller that this line needs service. The line is configured and acknowledged through a 32-bit register image: a write strobe loads the configuration fields and clears status flags written as 1. The read image is always visible on `rd_data_o`, so the usual acknowledge is to write back the value just read.

Register image (bit positions are part of the behaviour, since software decodes them): bit 0 trigger mode, bits 2:1 polarity, bit 3 interrupt enable, bit 4 unmask, bits 7:5 wake enables (bit 5 light idle, bit 6 suspend, bit 7 hibernate/off), bit 8 live input level (read only), bit 9 interrupt status (write 1 to clear), bit 10 wake status (write 1 to clear), bits 31:11 reserved.

Top module: `pin_irq_wake`

## Requirements
- R1: After reset every configuration field and both status flags read 0, and `pending_o` is low.
- R2: With bit 0 = 0 (edge mode) and bit 3 = 1, polarity 00 sets the interrupt status (bit 9) on a falling edge, 01 on a rising edge and 10 on either edge; the flag is visible on the cycle after the clock edge that sees the new input level.
- R3: With bit 0 = 1 (level mode) and bit 3 = 1, polarity 00 sets bit 9 while the input is low and 01 while it is high; while the active level persists the flag is set again on every clock, even right after a clear.
- R4: Polarity 11 in either mode, and polarity 10 in level mode, never set either status flag.
- R5: With bit 3 = 0 no event sets bit 9; a bit 9 already set is held.
- R6: `pending_o` is high exactly when bit 4 is 1 and bit 9 or bit 10 is 1; a masked line keeps its status flags.
- R7: A write with bit 9 (or bit 10) = 1 clears that flag, a 0 there leaves it; if a qualifying event for that flag occurs in the same cycle as the clear, the flag stays set.
- R8: The wake status (bit 10) sets on a qualifying event only when `pwr_state_i` is 1 (light idle) with bit 5 set, 2 (suspend) with bit 6 set, or 3 (hibernate) with bit 7 set; state 0 (running) never sets it, and bit 3 has no effect on it.
- R9: Bit 8 of `rd_data_o` always equals `pin_i`, whatever the configuration, and writes to it have no effect.
- R10: In edge mode only a new edge after a clear sets the status again; the input history resets to 0.
- R11: Reserved bits 31:11 always read 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register image |
| wr_data_i | input | 32 | Write data: configuration fields and write-1-to-clear status bits |
| pin_i | input | 1 | Debounced input level |
| pwr_state_i | input | 2 | Power state: 0 running, 1 light idle, 2 suspend, 3 hibernate/off |
| rd_data_o | output | 32 | Current register image |
| pending_o | output | 1 | Unmasked interrupt or wake status is set |

## Verification
The functions that can fall in the same cycle are the acknowledge (a write that clears a status flag) and the detection of a new qualifying event. The bench provokes the collision in two ways: it writes the clear on the very cycle a rising edge arrives, and it writes it while a level-mode line is held at its active level. It judges the outcome by reading back bit 9 and `pending_o` on the following cycle, which must both still be set.

// File: rtl/pin_irq_pkg.sv
`timescale 1ns/1ps
package pin_irq_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned WAKE_N  = 3;
  localparam int unsigned PWR_W   = 2;
  localparam int unsigned CFG_W   = 5 + WAKE_N;
  localparam int unsigned B_PIN   = CFG_W;
  localparam int unsigned B_ISTS  = CFG_W + 1;
  localparam int unsigned B_WSTS  = CFG_W + 2;
  localparam int unsigned STS_N   = 2;

  typedef enum logic [1:0] {
    POL_LOW  = 2'b00,
    POL_HIGH = 2'b01,
    POL_BOTH = 2'b10,
    POL_RSVD = 2'b11
  } pol_e;

  typedef enum logic [PWR_W-1:0] {
    PS_RUN       = 2'd0,
    PS_IDLE      = 2'd1,
    PS_SUSPEND   = 2'd2,
    PS_HIBERNATE = 2'd3
  } pwr_e;

  // packed msb first: wake_en[7:5], unmask[4], int_en[3], pol[2:1], level[0]
  typedef struct packed {
    logic [WAKE_N-1:0] wake_en;
    logic              unmask;
    logic              int_en;
    pol_e              pol;
    logic              level;
  } cfg_t;
endpackage

// File: rtl/pin_cfg_reg.sv
`timescale 1ns/1ps
module pin_cfg_reg
  import pin_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_en_i,
  input  cfg_t wr_cfg_i,
  output cfg_t cfg_o
);
  cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cfg_q <= '0;
    else if (wr_en_i) cfg_q <= wr_cfg_i;
  end

  assign cfg_o = cfg_q;

  a_r1_cfg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(cfg_o));
endmodule

// File: rtl/pin_evt_detect.sv
`timescale 1ns/1ps
module pin_evt_detect
  import pin_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic level_i,
  input  pol_e pol_i,
  output logic evt_o
);
  logic prev_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= pin_i;
  end

  assign rise = pin_i & ~prev_q;
  assign fall = ~pin_i & prev_q;

  always_comb begin
    unique case (pol_i)
      POL_LOW:  evt_o = level_i ? ~pin_i : fall;
      POL_HIGH: evt_o = level_i ?  pin_i : rise;
      POL_BOTH: evt_o = level_i ? 1'b0   : (rise | fall);
      default:  evt_o = 1'b0;
    endcase
  end

  // R10: an edge-mode event needs a change since the last clock
  a_r10_edge_needs_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!level_i && $stable(pin_i)) |-> !evt_o);
endmodule

// File: rtl/pin_sticky_bit.sv
`timescale 1ns/1ps
module pin_sticky_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic sts_o
);
  logic sts_q;

  // set has priority so an event coinciding with an acknowledge is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sts_q <= 1'b0;
    else if (set_i)  sts_q <= 1'b1;
    else if (clr_i)  sts_q <= 1'b0;
  end

  assign sts_o = sts_q;

  a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> sts_o);
  a_r7_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !sts_o);
endmodule

// File: rtl/pin_irq_wake.sv
`timescale 1ns/1ps
module pin_irq_wake
  import pin_irq_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             pin_i,
  input  logic [PWR_W-1:0] pwr_state_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             pending_o
);
  cfg_t             cfg;
  logic             evt;
  logic             wake_armed;
  logic [STS_N-1:0] sts_set, sts_clr, sts;
  logic             unused_wr_bits;

  assign unused_wr_bits = ^{wr_data_i[REG_W-1:B_WSTS+1], wr_data_i[B_PIN]};

  pin_cfg_reg u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_cfg_i (cfg_t'(wr_data_i[CFG_W-1:0])),
    .cfg_o    (cfg)
  );

  pin_evt_detect u_evt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pin_i   (pin_i),
    .level_i (cfg.level),
    .pol_i   (cfg.pol),
    .evt_o   (evt)
  );

  // wake enable index i serves power state i+1; running state arms nothing
  always_comb begin
    wake_armed = 1'b0;
    for (int i = 0; i < WAKE_N; i++) begin
      if (pwr_state_i == PWR_W'(i + 1)) wake_armed = cfg.wake_en[i];
    end
  end

  assign sts_set[0] = evt & cfg.int_en;
  assign sts_set[1] = evt & wake_armed;
  assign sts_clr[0] = wr_en_i & wr_data_i[B_ISTS];
  assign sts_clr[1] = wr_en_i & wr_data_i[B_WSTS];

  for (genvar g = 0; g < STS_N; g++) begin : g_sts
    pin_sticky_bit u_bit (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (sts_set[g]),
      .clr_i  (sts_clr[g]),
      .sts_o  (sts[g])
    );
  end

  always_comb begin
    rd_data_o            = '0;
    rd_data_o[CFG_W-1:0] = cfg;
    rd_data_o[B_PIN]     = pin_i;
    rd_data_o[B_ISTS]    = sts[0];
    rd_data_o[B_WSTS]    = sts[1];
  end

  assign pending_o = cfg.unmask & (|sts);

  a_r6_pending_needs_unmask: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pending_o |-> cfg.unmask);
  a_r4_rsvd_code_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg.pol == POL_RSVD && !sts[0]) |=> !sts[0]);
  a_r5_disabled_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg.int_en && !sts[0]) |=> !sts[0]);
  a_r8_running_no_wake: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwr_state_i == PS_RUN && !sts[1]) |=> !sts[1]);
endmodule

// File: tb/pin_irq_wake_bench.sv
`timescale 1ns/1ps
module pin_irq_wake_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [31:0] wr_data_i = '0;
  logic        pin_i = 1'b0;
  logic [1:0]  pwr_state_i = '0;
  logic [31:0] rd_data_o;
  logic        pending_o;

  always #2.5 clk_i = ~clk_i;

  pin_irq_wake u_pin_irq_wake (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .pin_i       (pin_i),
    .pwr_state_i (pwr_state_i),
    .rd_data_o   (rd_data_o),
    .pending_o   (pending_o)
  );

  typedef struct {
    logic [31:0] rd;
    logic        pend;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;

  // reference state built from the requirements
  logic [7:0] m_cfg  = '0;
  logic       m_prev = 1'b0;
  logic       m_ists = 1'b0;
  logic       m_wsts = 1'b0;
  logic       cur_pin = 1'b0;
  logic [1:0] cur_ps  = '0;

  function automatic logic model_evt(input logic [7:0] c, input logic prev, input logic p);
    logic lvl;
    lvl = c[0];
    case (c[2:1])
      2'b00:   return lvl ? ~p : (prev & ~p);
      2'b01:   return lvl ?  p : (~prev & p);
      2'b10:   return lvl ? 1'b0 : (prev ^ p);
      default: return 1'b0;
    endcase
  endfunction

  task automatic step(input logic p, input logic we, input logic [31:0] wd,
                      input logic [1:0] ps, input string tag);
    logic ev, armed, n_i, n_w;
    logic [7:0] n_cfg;
    exp_t e;
    @(negedge clk_i);
    pin_i = p; wr_en_i = we; wr_data_i = wd; pwr_state_i = ps;
    cur_pin = p; cur_ps = ps;
    ev = model_evt(m_cfg, m_prev, p);
    case (ps)
      2'd1:    armed = m_cfg[5];
      2'd2:    armed = m_cfg[6];
      2'd3:    armed = m_cfg[7];
      default: armed = 1'b0;
    endcase
    n_i   = (m_cfg[3] && ev) ? 1'b1 : ((we && wd[9])  ? 1'b0 : m_ists);
    n_w   = (armed && ev)    ? 1'b1 : ((we && wd[10]) ? 1'b0 : m_wsts);
    n_cfg = we ? wd[7:0] : m_cfg;
    @(posedge clk_i);
    #1;
    m_cfg = n_cfg; m_prev = p; m_ists = n_i; m_wsts = n_w;
    e.rd   = {21'b0, m_wsts, m_ists, p, m_cfg};
    e.pend = m_cfg[4] & (m_ists | m_wsts);
    e.tag  = tag;
    q.push_back(e);
  endtask

  task automatic wr(input logic [31:0] wd, input string tag);
    step(cur_pin, 1'b1, wd, cur_ps, tag);
  endtask

  task automatic drive_pin(input logic p, input string tag);
    step(p, 1'b0, 32'h0, cur_ps, tag);
  endtask

  task automatic set_ps(input logic [1:0] ps, input string tag);
    step(cur_pin, 1'b0, 32'h0, ps, tag);
  endtask

  // monitor: compares between edges, after the driver has pushed
  always @(posedge clk_i) begin
    #2;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_cmp++;
      if (rd_data_o !== e.rd || pending_o !== e.pend) begin
        n_bad++;
        $display("FAIL %s: rd_data=%h pending=%b expected rd_data=%h pending=%b",
                 e.tag, rd_data_o, pending_o, e.rd, e.pend);
      end
    end
  end

  logic done = 1'b0;

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;

    // R1 reset state
    drive_pin(1'b0, "R1");
    drive_pin(1'b0, "R1");

    // R11 reserved bits ignore writes
    wr(32'hFFFF_F800, "R11");
    drive_pin(1'b0, "R11");

    // R9 live input level, read only
    drive_pin(1'b1, "R9");
    wr(32'h0000_0100, "R9");
    drive_pin(1'b0, "R9");

    // R2 edge rising, R10 no retrigger while held
    wr(32'h1A, "R2");
    drive_pin(1'b1, "R2");
    wr(32'h21A, "R10");
    drive_pin(1'b1, "R10");
    drive_pin(1'b1, "R10");

    // R2 falling
    wr(32'h18, "R2");
    drive_pin(1'b0, "R2");
    wr(32'h218, "R2");
    drive_pin(1'b0, "R10");

    // R2 both edges
    wr(32'h1C, "R2");
    drive_pin(1'b1, "R2");
    wr(32'h21C, "R2");
    drive_pin(1'b0, "R2");
    wr(32'h21C, "R2");

    // R4 undefined codes
    wr(32'h1E, "R4");
    for (int i = 0; i < 4; i++) drive_pin(~cur_pin, "R4");
    wr(32'h1D, "R4");
    for (int i = 0; i < 4; i++) drive_pin(~cur_pin, "R4");
    wr(32'h1F, "R4");
    for (int i = 0; i < 4; i++) drive_pin(~cur_pin, "R4");

    // R3 level high, clear while held (R7 collision)
    drive_pin(1'b0, "R3");
    wr(32'h1B, "R3");
    drive_pin(1'b1, "R3");
    wr(32'h21B, "R7");
    drive_pin(1'b1, "R3");
    drive_pin(1'b0, "R3");
    wr(32'h21B, "R3");
    drive_pin(1'b0, "R3");
    // level low
    wr(32'h19, "R3");
    drive_pin(1'b0, "R3");
    drive_pin(1'b1, "R3");
    wr(32'h219, "R3");

    // R5 interrupt disabled
    wr(32'h12, "R5");
    drive_pin(1'b0, "R5");
    drive_pin(1'b1, "R5");
    drive_pin(1'b0, "R5");
    wr(32'h1A, "R5");
    drive_pin(1'b1, "R5");
    wr(32'h12, "R5");
    drive_pin(1'b0, "R5");
    drive_pin(1'b1, "R5");

    // R6 mask keeps status, gates pending
    wr(32'h0A, "R6");
    drive_pin(1'b1, "R6");
    wr(32'h1A, "R6");
    // R7 write of 0 at status leaves it
    wr(32'h1A, "R7");
    wr(32'h21A, "R7");
    // R7 clear on the cycle of a new edge
    drive_pin(1'b0, "R7");
    step(1'b1, 1'b1, 32'h21A, cur_ps, "R7");
    wr(32'h21A, "R7");

    // R8 wake per power state
    wr(32'h32, "R8");
    drive_pin(1'b0, "R8");
    set_ps(2'd1, "R8");
    drive_pin(1'b1, "R8");
    wr(32'h432, "R8");
    drive_pin(1'b0, "R8");
    set_ps(2'd2, "R8");
    drive_pin(1'b1, "R8");
    drive_pin(1'b0, "R8");
    wr(32'h52, "R8");
    drive_pin(1'b1, "R8");
    wr(32'h452, "R8");
    set_ps(2'd3, "R8");
    wr(32'h92, "R8");
    drive_pin(1'b0, "R8");
    drive_pin(1'b1, "R8");
    wr(32'h492, "R8");
    set_ps(2'd0, "R8");
    wr(32'hF2, "R8");
    drive_pin(1'b0, "R8");
    drive_pin(1'b1, "R8");
    // R8 with interrupt enable on, masked: wake still sets
    set_ps(2'd2, "R8");
    wr(32'h4A, "R8");
    drive_pin(1'b0, "R8");
    drive_pin(1'b1, "R8");
    wr(32'h65A, "R8");

    repeat (3) @(posedge clk_i);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule